// File: doc/BRIEF.md
# Edge-Latched Bytewide Memory Responder

This block stands in, inside a clocked design, for a bytewide nonvolatile memory as its bus pins see it. A fast system clock samples the active-low chip select, write strobe and output strobe through a synchronizer. Each memory cycle begins only on a sampled falling edge of chip select. That edge freezes the address, and decides whether the cycle opens as a write (write strobe already low) or as a read. Access time, precharge time and write-data setup time are counted in clock ticks. The data bus is split into an input byte, an output byte and a drive-enable pin that stands in for a tri-state pad.

A read drives the bus only once the access delay has run out, and only while the output strobe is low. A write is committed to an internal register array when the write strobe or chip select rises, whichever comes first, and only one byte is committed per cycle. A started cycle runs to the end of its access time even if chip select rises early. A mandatory precharge interval with chip select high then has to pass. A falling edge that arrives too early is ignored, and it raises a sticky timing-error flag. So does write data that changes too close to the end of a write.

The address port is wider than the storage. Address bit k is folded onto storage index bit (k mod STORE_AW) by exclusive-or, so the array size can be set apart from the pin-level address width.

Top module: `edgemem_responder`

## Requirements
- R1: A cycle starts only on an accepted falling edge of ce_n. With the default two synchronizer stages, and with inputs changed between clock edges, the cycle's state registers start at the third rising clock edge after ce_n falls.
- R2: The address is taken at the accepted falling edge. Any change of addr more than two clock periods after that edge has no effect on the byte read or written in that cycle.
- R3: In a read cycle with oe_n held low, dout_oe stays low through the (ACC_TICKS+2)th rising edge after ce_n falls. It is high after the (ACC_TICKS+3)th rising edge, and dout then carries the stored byte.
- R4: dout_oe is high only while oe_n is low. If oe_n falls after the access has completed, dout_oe rises after the second rising edge. It drops after the second rising edge following a rise of oe_n or of ce_n.
- R5: If we_n is low when ce_n falls, the cycle is a write and dout_oe stays low for the whole cycle, whatever the level of oe_n.
- R6: If we_n falls while a read cycle is active, dout_oe drops after the second rising edge following that fall. The byte on din is committed when we_n rises, and a later read of that address returns it.
- R7: A write ends at the first rise of we_n or ce_n. Only one byte is committed per cycle: a second we_n pulse in the same cycle, and a change of din more than one clock period after the end, have no effect.
- R8: A falling edge of ce_n is accepted only if ce_n was high for at least PRE_TICKS clock periods before it, and at least ACC_TICKS+1 clock periods have passed since the previous accepted falling edge. A falling edge that is not accepted causes no drive and no write.
- R9: timing_err goes high on a rejected falling edge or a setup violation, and it stays high until reset.
- R10: If din changed fewer than DSU_TICKS clock periods before the end of a write, timing_err is set. The byte present at the end is still committed.
- R11: After reset, dout_oe and timing_err are low, and the first falling edge of ce_n is accepted.
- R12: The storage index is the low STORE_AW address bits, with each higher bit k XORed into index bit (k mod STORE_AW). With defaults, address 0x4005 and address 0x0015 select the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select; its falling edge starts a cycle |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | ADDR_W | Byte address, taken at the accepted falling edge of ce_n |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus |
| dout_oe | output | 1 | High when the block drives the bus |
| timing_err | output | 1 | Sticky flag for a broken timing rule |

## Verification
The assertions check, on every cycle, these properties: the latched address holds still while a cycle is active, and a cycle becomes active only out of a sampled falling edge. Drive is released in the cycle after a write-strobe fall and never follows a rejected edge. The error flag is sticky, and every commit lands in the array. The exact tick on which data is driven, the precharge and cycle-length boundaries, the choice between the two write styles, the single commit per cycle and the address folding can only be shown by the bench. Its scenarios drive strobe sequences to these boundaries and compare the read bytes against a model.

// File: rtl/edgemem_pkg.sv
`timescale 1ns/1ps
package edgemem_pkg;
  typedef enum logic {CYC_IDLE = 1'b0, CYC_ACTIVE = 1'b1} cyc_state_e;

  function automatic int cnt_width(int maxv);
    return (maxv < 1) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/edgemem_sync.sv
`timescale 1ns/1ps
module edgemem_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/edgemem_ctrl.sv
`timescale 1ns/1ps
module edgemem_ctrl
  import edgemem_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int ACC_TICKS = 14,
  parameter int PRE_TICKS = 12,
  parameter int DSU_TICKS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] din_d,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout_en,
  output logic              timing_err
);
  localparam int ACC_W = cnt_width(ACC_TICKS);
  localparam int PRE_W = cnt_width(PRE_TICKS);
  localparam int DSU_W = cnt_width(DSU_TICKS);
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(ACC_TICKS);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_TICKS);
  localparam logic [DSU_W-1:0] DSU_MAX = DSU_W'(DSU_TICKS);

  cyc_state_e        state;
  logic              ce_q, we_q;
  logic [ACC_W-1:0]  acc_cnt;
  logic [PRE_W-1:0]  pc_cnt;
  logic [DSU_W-1:0]  ds_cnt;
  logic [DATA_W-1:0] din_q;
  logic              wr_cyc, wr_open, wr_done;

  logic ce_fall, ce_rise, we_fall, we_rise;
  logic acc_done, pc_done, accept, reject, din_chg, setup_bad;
  logic [DSU_W:0] stable_ticks;

  assign ce_fall  = ce_q & ~ce_s;
  assign ce_rise  = ~ce_q & ce_s;
  assign we_fall  = we_q & ~we_s;
  assign we_rise  = ~we_q & we_s;
  assign acc_done = (acc_cnt >= ACC_MAX);
  assign pc_done  = (pc_cnt >= PRE_MAX);
  assign accept   = ce_fall & acc_done & pc_done;
  assign reject   = ce_fall & ~accept;

  assign din_chg      = (din_d != din_q);
  assign stable_ticks = din_chg ? '0 : ({1'b0, ds_cnt} + 1'b1);

  assign wr_en     = (state == CYC_ACTIVE) & wr_open & (we_rise | ce_rise);
  assign wr_data   = din_d;
  assign setup_bad = wr_en & (stable_ticks < {1'b0, DSU_MAX});

  assign dout_en = (state == CYC_ACTIVE) & ~ce_s & we_s & ~oe_s & ~wr_cyc & acc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CYC_IDLE;
      ce_q       <= 1'b1;
      we_q       <= 1'b1;
      addr_lat   <= '0;
      acc_cnt    <= ACC_MAX;
      pc_cnt     <= PRE_MAX;
      ds_cnt     <= '0;
      din_q      <= '0;
      wr_cyc     <= 1'b0;
      wr_open    <= 1'b0;
      wr_done    <= 1'b0;
      timing_err <= 1'b0;
    end else begin
      ce_q  <= ce_s;
      we_q  <= we_s;
      din_q <= din_d;
      pc_cnt <= ce_s ? (pc_done ? pc_cnt : pc_cnt + 1'b1) : '0;
      ds_cnt <= din_chg ? '0 : ((ds_cnt >= DSU_MAX) ? ds_cnt : ds_cnt + 1'b1);
      if (accept) begin
        state    <= CYC_ACTIVE;
        addr_lat <= addr_d;
        acc_cnt  <= '0;
        wr_cyc   <= ~we_s;
        wr_open  <= ~we_s;
        wr_done  <= 1'b0;
      end else begin
        if (!acc_done) acc_cnt <= acc_cnt + 1'b1;
        if (state == CYC_ACTIVE) begin
          if (wr_en) begin
            wr_open <= 1'b0;
            wr_done <= 1'b1;
          end else if (!wr_open && !wr_done && we_fall) begin
            wr_open <= 1'b1;
            wr_cyc  <= 1'b1;
          end
          if (ce_rise) begin
            state   <= CYC_IDLE;
            wr_open <= 1'b0;
          end
        end
      end
      if (reject || setup_bad) timing_err <= 1'b1;
    end
  end

  // R2: latched address frozen for the whole active cycle
  p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYC_ACTIVE && $past(state) == CYC_ACTIVE) |-> $stable(addr_lat))
    else $error("p_addr_frozen_r2");

  // R1: a cycle becomes active only after a sampled falling edge
  p_start_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYC_ACTIVE && $past(state) == CYC_IDLE) |-> $past(ce_q && !ce_s))
    else $error("p_start_on_fall_r1");

  // R6: write-strobe fall inside a cycle releases the bus next cycle
  p_release_on_wefall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYC_ACTIVE && we_fall) |=> !dout_en)
    else $error("p_release_on_wefall_r6");

  // R8: a rejected edge never leads to drive
  p_no_drive_rejected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !dout_en)
    else $error("p_no_drive_rejected_r8");

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err)
    else $error("p_err_sticky_r9");
endmodule

// File: rtl/edgemem_store.sv
`timescale 1ns/1ps
module edgemem_store #(
  parameter int ADDR_W   = 15,
  parameter int STORE_AW = 10,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [STORE_AW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int k = 0; k < ADDR_W; k++) idx[k % STORE_AW] = idx[k % STORE_AW] ^ addr[k];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  assign rd_data = mem[idx];

  // R6: every commit lands in the array at the folded index
  p_commit_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(idx)] == $past(wr_data)))
    else $error("p_commit_lands_r6");
endmodule

// File: rtl/edgemem_responder.sv
`timescale 1ns/1ps
module edgemem_responder #(
  parameter int ADDR_W      = 15,
  parameter int STORE_AW    = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACC_TICKS   = 14,
  parameter int PRE_TICKS   = 12,
  parameter int DSU_TICKS   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              timing_err
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [2:0]        strb_q;
  logic [BUS_W-1:0]  bus_q;
  logic [ADDR_W-1:0] addr_lat;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;

  edgemem_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(strb_q)
  );

  edgemem_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_bus_align (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_q)
  );

  edgemem_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_TICKS(ACC_TICKS),
    .PRE_TICKS(PRE_TICKS), .DSU_TICKS(DSU_TICKS)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ce_s(strb_q[2]), .we_s(strb_q[1]), .oe_s(strb_q[0]),
    .addr_d(bus_q[BUS_W-1:DATA_W]), .din_d(bus_q[DATA_W-1:0]),
    .addr_lat(addr_lat), .wr_en(wr_en), .wr_data(wr_data),
    .dout_en(dout_oe), .timing_err(timing_err)
  );

  edgemem_store #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n), .addr(addr_lat), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(dout)
  );
endmodule

// File: tb/test_edgemem_responder.sv
`timescale 1ns/1ps
module test_edgemem_responder;
  localparam int ACC = 14;
  localparam int PRE = 12;
  localparam int DSU = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_oe, timing_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] model [1024];
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  edgemem_responder i_edgemem_responder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .timing_err(timing_err)
  );

  function automatic logic [9:0] fold(logic [14:0] a);
    return a[9:0] ^ {5'b0, a[14:10]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each new drive episode pops one expected byte
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (dout_oe && !prev_oe) begin
      if (exp_q.size() == 0) chk(0, "R5 R8 unexpected drive", int'(dout), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(dout == e, "R2 R3 read data", int'(dout), int'(e));
      end
    end
    prev_oe = dout_oe;
  end

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(dout_oe == 1'b0, "R11 drive after reset", dout_oe, 0);
    chk(timing_err == 1'b0, "R11 flag after reset", timing_err, 0);
    step(PRE);
  endtask

  task automatic read_cyc(logic [14:0] a, int hi);
    addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    exp_q.push_back(model[fold(a)]);
    step(3);
    addr = ~a;
    step(ACC - 1);
    chk(dout_oe == 1'b0, "R3 no drive before access", dout_oe, 0);
    step(1);
    chk(dout_oe == 1'b1, "R1 R3 drive at access", dout_oe, 1);
    step(3);
    ce_n = 1'b1; oe_n = 1'b1;
    step(2);
    chk(dout_oe == 1'b0, "R4 release on ce high", dout_oe, 0);
    step(hi - 2);
  endtask

  task automatic write_ce(logic [14:0] a, logic [7:0] d);
    addr = a; din = d; we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
    step(3);
    addr = ~a;
    step(ACC + 1);
    chk(dout_oe == 1'b0, "R5 no drive in write", dout_oe, 0);
    step(2);
    ce_n = 1'b1;
    step(2);
    din = ~d; we_n = 1'b1; oe_n = 1'b1;
    step(PRE + 2);
    model[fold(a)] = d;
  endtask

  task automatic write_we(logic [14:0] a, logic [7:0] d);
    addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    exp_q.push_back(model[fold(a)]);
    step(ACC + 4);
    chk(dout_oe == 1'b1, "R6 read phase drives", dout_oe, 1);
    we_n = 1'b0; din = d;
    step(2);
    chk(dout_oe == 1'b0, "R6 release on we fall", dout_oe, 0);
    step(DSU - 2);
    we_n = 1'b1;
    step(3);
    we_n = 1'b0; din = d ^ 8'hFF;
    step(DSU + 1);
    we_n = 1'b1;
    step(3);
    chk(dout_oe == 1'b0, "R7 no drive after write", dout_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    step(PRE + 2);
    model[fold(a)] = d;
  endtask

  initial begin
    do_reset();
    // R5, R11: first cycle after reset accepted, CE-controlled write
    write_ce(15'h0123, 8'hA5);
    write_ce(15'h0456, 8'h5A);
    read_cyc(15'h0123, PRE + 2);
    read_cyc(15'h0456, PRE);           // R8: precharge of exactly PRE ticks
    read_cyc(15'h0123, PRE + 2);
    chk(timing_err == 1'b0, "R8 exact precharge accepted", timing_err, 0);
    // R6, R7: WE-controlled write with a second ignored pulse
    write_we(15'h0456, 8'hC3);
    read_cyc(15'h0456, PRE + 2);
    // R12: folded aliasing
    write_ce(15'h0015, 8'h3C);
    write_ce(15'h0005, 8'h77);
    read_cyc(15'h4005, PRE + 2);
    read_cyc(15'h0005, PRE + 2);
    // R4: late output strobe
    addr = 15'h0123; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    exp_q.push_back(model[fold(15'h0123)]);
    step(ACC + 6);
    chk(dout_oe == 1'b0, "R4 no drive with oe high", dout_oe, 0);
    oe_n = 1'b0;
    step(1);
    chk(dout_oe == 1'b0, "R4 oe sync delay", dout_oe, 0);
    step(1);
    chk(dout_oe == 1'b1, "R4 drive after oe low", dout_oe, 1);
    step(2);
    oe_n = 1'b1;
    step(2);
    chk(dout_oe == 1'b0, "R4 release on oe high", dout_oe, 0);
    ce_n = 1'b1;
    step(PRE + 2);
    // R8: cycle length exactly ACC+1 accepted after early ce rise
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    step(3);
    ce_n = 1'b1;
    step(PRE);
    read_cyc(15'h0456, PRE + 2);
    chk(timing_err == 1'b0, "R8 minimum cycle accepted", timing_err, 0);
    // R8, R9: early ce rise then fall too soon is rejected
    ce_n = 1'b0; oe_n = 1'b0;
    step(1);
    ce_n = 1'b1;
    step(PRE);
    ce_n = 1'b0;
    step(ACC + 6);
    chk(dout_oe == 1'b0, "R8 rejected edge no drive", dout_oe, 0);
    chk(timing_err == 1'b1, "R9 flag on rejected edge", timing_err, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    step(PRE + 4);
    chk(timing_err == 1'b1, "R9 flag sticky", timing_err, 1);
    // R8: precharge one tick short is rejected
    do_reset();
    read_cyc(15'h0123, PRE - 1);
    addr = 15'h0123; din = 8'h11; we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b0;
    step(ACC + 4);
    ce_n = 1'b1;
    step(2);
    we_n = 1'b1;
    step(PRE + 2);
    chk(timing_err == 1'b1, "R8 short precharge rejected", timing_err, 1);
    read_cyc(15'h0123, PRE + 2);       // R8: rejected write left byte unchanged
    // R10: setup violation, byte still committed
    do_reset();
    addr = 15'h0200; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    step(4);
    we_n = 1'b0; din = 8'h12;
    step(DSU + 2);
    din = 8'h34;
    step(2);
    chk(timing_err == 1'b0, "R10 flag before end", timing_err, 0);
    we_n = 1'b1;
    step(4);
    chk(timing_err == 1'b1, "R10 flag on setup violation", timing_err, 1);
    ce_n = 1'b1;
    step(PRE + 2);
    model[fold(15'h0200)] = 8'h34;
    read_cyc(15'h0200, PRE + 2);
    step(4);
    chk(exp_q.size() == 0, "R3 all expected reads seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule